// File: doc/BRIEF.md
# Angle-Commanded PWM Rotation Controller

This block turns a single rotation command into a target coordinate pair and a burst of pulse-width-modulated drive. A command carries an angle in whole degrees and a direction bit. The angle is held in a command register for the rest of the rotation. Two tables built at elaboration give the target point on a circle of radius 2^FRAC: the horizontal output comes from the sine table and the vertical output from the cosine table. The on-time of the drive pulse is found from the held angle and the direction. Clockwise adds to a base width and anticlockwise subtracts from it, so a larger angle pulls the pulse further from the base in either direction.

Commands enter through a valid/ready handshake that allows exactly one transfer per reset. `cmd_ready` is high only in the reference state. A command transfers on the rising edge where `cmd_valid` and `cmd_ready` are both high. After that, `cmd_ready` stays low whatever `cmd_valid` does, and a source must hold its command until it sees ready. The controller runs a fixed number of PWM periods and then parks with `done` high and its coordinates frozen. Only `rst` brings it back to the reference position, where it can take another command. `pwm`, `done` and the coordinates are plain level outputs.

Top module: `rot_angle_ctrl`

## Requirements
- R1: While `rst` is high and right after it is released: `cmd_ready` = 1, `done` = 0, `pwm` = 0, `x_out` = 0 and `y_out` = 2^FRAC (the reference position, angle 0).
- R2: A command transfers on the rising edge where `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` then stays 0 until the next reset.
- R3: The coordinates are updated on the second rising edge after the transfer edge. They then hold `x_out` = floor(2^FRAC·sin θ + 0.001) and `y_out` = floor(2^FRAC·cos θ + 0.001), where θ is the angle in degrees. With FRAC = 11 this gives 355/2016 at 10° and 700/1924 at 20°. Between the transfer edge and that update the coordinates keep their reference values.
- R4: A commanded angle above MAX_ANGLE (90) is treated as MAX_ANGLE, both for the coordinates and for the pulse width.
- R5: When `cmd_dir` = 0 (clockwise), the on-time is min(BASE + K·θ, PERIOD−1) clocks.
- R6: When `cmd_dir` = 1 (anticlockwise), the on-time is max(BASE − K·θ, 0) clocks.
- R7: The run lasts RUN_PERIODS periods of PERIOD clocks each. In every period, `pwm` is high for the first on-time clocks and low for the rest. The run starts on the second edge after the transfer edge.
- R8: When the run ends, `done` goes to 1 and stays there until reset. While `done` is 1, `pwm` is 0, and `cmd_valid` has no effect on any output.
- R9: `x_out` and `y_out` do not change during the run or while `done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; returns to the reference position |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Controller at the reference position and able to take a command |
| cmd_angle | input | ANGLE_W | Commanded angle in degrees |
| cmd_dir | input | 1 | 0 = clockwise, 1 = anticlockwise |
| pwm | output | 1 | Drive pulse |
| x_out | output | COORD_W | Target horizontal coordinate (sine) |
| y_out | output | COORD_W | Target vertical coordinate (cosine) |
| done | output | 1 | Rotation finished; waiting for reset |

## Verification
The bench builds the controller with PERIOD = 64, BASE = 32, K = 1 and RUN_PERIODS = 2, and keeps the default table range and precision. This short period keeps each rotation to about 130 clocks. It also places both saturation limits inside the angle range: clockwise pulses clip at 63 from 31° upward, and anticlockwise pulses reach zero from 32° upward. The bench checks the exact boundary angles on both sides of each limit. It also covers the 90° clamp for an out-of-range angle, and the stated table values at 10° and 20°.

// File: rtl/rot_pkg.sv
package rot_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LATCH,
    ST_RUN,
    ST_DONE
  } rot_state_e;

  // Table entry: floor(2^frac_bits * trig(deg) + 0.001), evaluated at elaboration
  function automatic int trig_entry(input int deg, input bit want_sin, input int frac_bits);
    real rad;
    real v;
    real scale;
    rad   = real'(deg) * 3.14159265358979 / 180.0;
    v     = want_sin ? $sin(rad) : $cos(rad);
    scale = real'(64'(1) << frac_bits);
    return $rtoi($floor(scale * v + 0.001));
  endfunction

endpackage

// File: rtl/rot_trig_rom.sv
module rot_trig_rom #(
  parameter int ANGLE_W   = 7,
  parameter int MAX_ANGLE = 90,
  parameter int COORD_W   = 13,
  parameter int FRAC      = 11
) (
  input  logic [ANGLE_W-1:0] angle,
  output logic [COORD_W-1:0] x_val,
  output logic [COORD_W-1:0] y_val
);
  import rot_pkg::*;

  localparam int N = MAX_ANGLE + 1;

  logic [COORD_W-1:0] sin_tbl [N];
  logic [COORD_W-1:0] cos_tbl [N];

  generate
    for (genvar g = 0; g < N; g++) begin : g_entry
      localparam int SV = trig_entry(g, 1'b1, FRAC);
      localparam int CV = trig_entry(g, 1'b0, FRAC);
      assign sin_tbl[g] = COORD_W'(SV);
      assign cos_tbl[g] = COORD_W'(CV);
    end
  endgenerate

  // angle is already clamped to MAX_ANGLE by the caller
  assign x_val = sin_tbl[angle];
  assign y_val = cos_tbl[angle];

endmodule

// File: rtl/rot_pulse_width.sv
module rot_pulse_width #(
  parameter int ANGLE_W = 7,
  parameter int CNT_W   = 10,
  parameter int PERIOD  = 1024,
  parameter int BASE    = 512,
  parameter int K       = 4
) (
  input  logic [ANGLE_W-1:0] angle,
  input  logic               dir_ccw,
  output logic [CNT_W-1:0]   on_time
);

  localparam int TOP = PERIOD - 1;

  always_comb begin
    int prod;
    int raw;
    prod = K * int'(angle);
    // clockwise widens the pulse, anticlockwise narrows it
    raw  = dir_ccw ? (BASE - prod) : (BASE + prod);
    if (raw < 0) begin
      raw = 0;
    end else if (raw > TOP) begin
      raw = TOP;
    end
    on_time = CNT_W'(raw);
  end

endmodule

// File: rtl/rot_pwm_gen.sv
module rot_pwm_gen #(
  parameter int PERIOD      = 1024,
  parameter int RUN_PERIODS = 8,
  parameter int CNT_W       = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             active,
  input  logic [CNT_W-1:0] on_time,
  output logic             pwm,
  output logic             last
);

  localparam int PER_W = (RUN_PERIODS < 2) ? 1 : $clog2(RUN_PERIODS);
  localparam logic [CNT_W-1:0] WRAP_AT = CNT_W'(PERIOD - 1);
  localparam logic [PER_W-1:0] LAST_PER = PER_W'(RUN_PERIODS - 1);

  logic [CNT_W-1:0] phase;
  logic [PER_W-1:0] per_idx;
  logic             wrap;

  assign wrap = (phase == WRAP_AT);

  always_ff @(posedge clk) begin
    if (rst || start) begin
      phase   <= '0;
      per_idx <= '0;
    end else if (active) begin
      if (wrap) begin
        phase   <= '0;
        per_idx <= per_idx + 1'b1;
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

  assign last = active && wrap && (per_idx == LAST_PER);
  assign pwm  = active && (phase < on_time);

endmodule

// File: rtl/rot_angle_ctrl.sv
module rot_angle_ctrl #(
  parameter int ANGLE_W     = 7,
  parameter int MAX_ANGLE   = 90,
  parameter int COORD_W     = 13,
  parameter int FRAC        = 11,
  parameter int PERIOD      = 1024,
  parameter int BASE        = 512,
  parameter int K           = 4,
  parameter int RUN_PERIODS = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [ANGLE_W-1:0] cmd_angle,
  input  logic               cmd_dir,
  output logic               pwm,
  output logic [COORD_W-1:0] x_out,
  output logic [COORD_W-1:0] y_out,
  output logic               done
);
  import rot_pkg::*;

  localparam int CNT_W = $clog2(PERIOD);
  localparam logic [ANGLE_W-1:0] ANG_LIM = ANGLE_W'(MAX_ANGLE);
  localparam logic [COORD_W-1:0] REF_X = COORD_W'(trig_entry(0, 1'b1, FRAC));
  localparam logic [COORD_W-1:0] REF_Y = COORD_W'(trig_entry(0, 1'b0, FRAC));

  rot_state_e         state;
  logic [ANGLE_W-1:0] z_angle;
  logic               z_dir;
  logic [ANGLE_W-1:0] cmd_lim;
  logic [COORD_W-1:0] tbl_x;
  logic [COORD_W-1:0] tbl_y;
  logic [CNT_W-1:0]   width_calc;
  logic [CNT_W-1:0]   width_q;
  logic               run_last;
  logic               accept;

  assign cmd_ready = (state == ST_IDLE);
  assign done      = (state == ST_DONE);
  assign accept    = cmd_valid && cmd_ready;
  assign cmd_lim   = (cmd_angle > ANG_LIM) ? ANG_LIM : cmd_angle;

  rot_trig_rom #(
    .ANGLE_W  (ANGLE_W),
    .MAX_ANGLE(MAX_ANGLE),
    .COORD_W  (COORD_W),
    .FRAC     (FRAC)
  ) u_rom (
    .angle(z_angle),
    .x_val(tbl_x),
    .y_val(tbl_y)
  );

  rot_pulse_width #(
    .ANGLE_W(ANGLE_W),
    .CNT_W  (CNT_W),
    .PERIOD (PERIOD),
    .BASE   (BASE),
    .K      (K)
  ) u_width (
    .angle  (z_angle),
    .dir_ccw(z_dir),
    .on_time(width_calc)
  );

  rot_pwm_gen #(
    .PERIOD     (PERIOD),
    .RUN_PERIODS(RUN_PERIODS),
    .CNT_W      (CNT_W)
  ) u_gen (
    .clk    (clk),
    .rst    (rst),
    .start  (state == ST_LATCH),
    .active (state == ST_RUN),
    .on_time(width_q),
    .pwm    (pwm),
    .last   (run_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      z_angle <= '0;
      z_dir   <= 1'b0;
      width_q <= '0;
      x_out   <= REF_X;
      y_out   <= REF_Y;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            z_angle <= cmd_lim;
            z_dir   <= cmd_dir;
            state   <= ST_LATCH;
          end
        end
        ST_LATCH: begin
          x_out   <= tbl_x;
          y_out   <= tbl_y;
          width_q <= width_calc;
          state   <= ST_RUN;
        end
        ST_RUN: begin
          if (run_last) begin
            state <= ST_DONE;
          end
        end
        ST_DONE: begin
          state <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rot_angle_ctrl_chk.sv
module rot_angle_ctrl_chk #(
  parameter int COORD_W = 13,
  parameter int FRAC    = 11
) (
  input logic               clk,
  input logic               rst,
  input logic               cmd_valid,
  input logic               cmd_ready,
  input logic               pwm,
  input logic               done,
  input logic [COORD_W-1:0] x_out,
  input logic [COORD_W-1:0] y_out
);

  localparam logic [COORD_W-1:0] FULL = COORD_W'(64'(1) << FRAC);

  // R2
  accept_closes_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  // R2
  ready_stays_low_chk: assert property (@(posedge clk) disable iff (rst)
    !cmd_ready |=> !cmd_ready);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> (!pwm && !done));

  // R8
  done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!pwm && !cmd_ready));

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> (done && $stable(x_out) && $stable(y_out)));

  // R9
  coord_hold_chk: assert property (@(posedge clk) disable iff (rst)
    pwm |=> ($stable(x_out) && $stable(y_out)));

  // R3
  coord_range_chk: assert property (@(posedge clk) disable iff (rst)
    (x_out <= FULL) && (y_out <= FULL));

endmodule

bind rot_angle_ctrl rot_angle_ctrl_chk #(
  .COORD_W(COORD_W),
  .FRAC   (FRAC)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready),
  .pwm      (pwm),
  .done     (done),
  .x_out    (x_out),
  .y_out    (y_out)
);

// File: tb/rot_angle_ctrl_test.sv
`timescale 1ns/1ps
module rot_angle_ctrl_test;

  localparam int ANGLE_W = 7;
  localparam int COORD_W = 13;
  localparam int FRAC    = 11;
  localparam int TB_PER  = 64;
  localparam int TB_BASE = 32;
  localparam int TB_K    = 1;
  localparam int TB_RUNS = 2;
  localparam int MAXA    = 90;

  typedef struct {
    int    x;
    int    y;
    int    hi;
    int    run;
    string tag;
  } exp_t;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               cmd_valid = 1'b0;
  logic               cmd_ready;
  logic [ANGLE_W-1:0] cmd_angle = '0;
  logic               cmd_dir = 1'b0;
  logic               pwm;
  logic [COORD_W-1:0] x_out;
  logic [COORD_W-1:0] y_out;
  logic               done;

  int   checks = 0;
  int   errors = 0;
  exp_t exp_q[$];

  always #10 clk = ~clk;

  rot_angle_ctrl #(
    .ANGLE_W    (ANGLE_W),
    .MAX_ANGLE  (MAXA),
    .COORD_W    (COORD_W),
    .FRAC       (FRAC),
    .PERIOD     (TB_PER),
    .BASE       (TB_BASE),
    .K          (TB_K),
    .RUN_PERIODS(TB_RUNS)
  ) uut (
    .clk      (clk),
    .rst      (rst),
    .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready),
    .cmd_angle(cmd_angle),
    .cmd_dir  (cmd_dir),
    .pwm      (pwm),
    .x_out    (x_out),
    .y_out    (y_out),
    .done     (done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int trig_ref(input int deg, input bit want_sin);
    real r;
    real v;
    r = real'(deg) * 3.14159265358979 / 180.0;
    v = want_sin ? $sin(r) : $cos(r);
    return $rtoi($floor(2048.0 * v + 0.001));
  endfunction

  // Monitor: measures each run and compares with the scoreboard head
  int  mon_hi = 0;
  int  mon_run = 0;
  int  mon_max = 0;
  bit  mon_seen = 1'b0;
  always @(negedge clk) begin
    if (rst) begin
      mon_hi = 0; mon_run = 0; mon_max = 0; mon_seen = 1'b0;
    end else begin
      if (pwm) begin
        mon_hi++;
        mon_run++;
        if (mon_run > mon_max) mon_max = mon_run;
      end else begin
        mon_run = 0;
      end
      if (done && !mon_seen) begin
        mon_seen = 1'b1;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8 done without command", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(mon_hi == e.hi, {e.tag, " R7 high cycles"}, mon_hi, e.hi);
          chk(mon_max == e.run, {e.tag, " R7 pulse width"}, mon_max, e.run);
          chk(int'(x_out) == e.x, {e.tag, " R9 x held"}, int'(x_out), e.x);
          chk(int'(y_out) == e.y, {e.tag, " R9 y held"}, int'(y_out), e.y);
        end
      end
    end
  end

  task automatic do_reset();
    rst = 1'b1;
    cmd_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(cmd_ready == 1'b1, "R1 ready", int'(cmd_ready), 1);
    chk(int'(x_out) == 0, "R1 x ref", int'(x_out), 0);
    chk(int'(y_out) == 2048, "R1 y ref", int'(y_out), 2048);
    chk(!pwm && !done, "R1 pwm/done", int'({pwm, done}), 0);
  endtask

  task automatic run_cmd(input int ang, input bit d, input string tag);
    exp_t e;
    int a;
    int on;
    a  = (ang > MAXA) ? MAXA : ang;
    on = d ? (TB_BASE - TB_K * a) : (TB_BASE + TB_K * a);
    if (on < 0) on = 0;
    if (on > TB_PER - 1) on = TB_PER - 1;
    e.x = trig_ref(a, 1'b1);
    e.y = trig_ref(a, 1'b0);
    e.hi = TB_RUNS * on;
    e.run = on;
    e.tag = tag;
    exp_q.push_back(e);

    @(negedge clk);
    cmd_angle = ANGLE_W'(ang);
    cmd_dir   = d;
    cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    // R2 transfer closes ready; R3 coordinates still at reference
    chk(cmd_ready == 1'b0, {tag, " R2 ready low"}, int'(cmd_ready), 0);
    chk(int'(x_out) == 0 && int'(y_out) == 2048, {tag, " R3 latency"}, int'(x_out), 0);
    @(negedge clk);
    chk(int'(x_out) == e.x, {tag, " R3 x"}, int'(x_out), e.x);
    chk(int'(y_out) == e.y, {tag, " R3 y"}, int'(y_out), e.y);
    repeat (40) @(negedge clk);
    chk(int'(x_out) == e.x && !done, {tag, " R9 mid-run"}, int'(x_out), e.x);
    while (!done) @(negedge clk);

    // R8: commands while done are ignored
    cmd_angle = ANGLE_W'(5);
    cmd_dir   = ~d;
    cmd_valid = 1'b1;
    repeat (8) begin
      @(negedge clk);
      chk(done && !pwm && !cmd_ready, {tag, " R8 parked"}, int'({done, pwm, cmd_ready}), 4);
    end
    chk(int'(x_out) == e.x && int'(y_out) == e.y, {tag, " R8 coords unchanged"}, int'(x_out), e.x);
    cmd_valid = 1'b0;
    do_reset();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    run_cmd(10, 1'b0, "R5 cw 10");
    run_cmd(20, 1'b1, "R6 ccw 20");
    run_cmd(0, 1'b0, "R5 cw 0");
    run_cmd(31, 1'b0, "R5 cw 31 edge");
    run_cmd(45, 1'b0, "R5 cw 45 sat");
    run_cmd(32, 1'b1, "R6 ccw 32 zero");
    run_cmd(60, 1'b1, "R6 ccw 60 sat");
    run_cmd(120, 1'b0, "R4 clamp 120");
    run_cmd(90, 1'b1, "R4 ccw 90");
    chk(exp_q.size() == 0, "R7 all runs seen", exp_q.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule